// File: doc/BRIEF.md
# Status Output Pin Selector

This block drives the single open-drain status pin of a serially programmed frequency synthesizer. A 3-bit select register chooses what the pin shows. It can stay released, report loss of loop lock, raise a sticky end-of-measurement flag for the frequency counter, or mirror the level of one of two general-purpose I/O pins. The pin is modelled as an active-low drive enable: a registered 0 pulls the pin low, and a 1 leaves it at high impedance.

The serial control port has priority over the select register. While chip enable is high in a write mode, the pin is released. While chip enable is high in read mode, the pin carries the read-back data bit, which changes on falling edges of the serial clock. The end-of-measurement flag is set when the counter reports completion. It is cleared when a new count starts or when a serial transaction begins, so firmware can poll the pin between transactions. The counter and the serial shift register sit outside this block. All control inputs are in the block's clock domain, except the I/O pin levels, which pass through a synchronizer.

Top module: `stat_pin_sel`

## Requirements
- R1: During and after synchronous reset, the pin is released (`pin_n`=1), the select register holds 000 and the end-of-measurement flag is clear.
- R2: The select register loads `sel_in` on a clock edge where `sel_we`=1. Select codes 000, 011, 100 and 111 keep the pin released.
- R3: With select 001 and chip enable low, the pin is pulled low one cycle after `pll_locked` is sampled 0, and released one cycle after it is sampled 1.
- R4: With select 010 and chip enable low, a `cnt_done` pulse pulls the pin low from the next cycle on. It stays low until a clear event occurs.
- R5: Each of these clears the flag: a 0-to-1 change of `cnt_en`, and a 0-to-1 change of `ce`. When `cnt_done` comes in the same cycle as a clear event, the flag ends set.
- R6: Select 101 follows the level of I/O pin 0 and select 110 follows I/O pin 1. The latency is three cycles: two synchronizer stages and the output register. If the chosen pin's `io_is_out` bit is 1, the status pin is released instead.
- R7: While `ce`=1 with `ser_mode` 00, 01 or 11 (write modes), the pin is released one cycle later, whatever the select code.
- R8: While `ce`=1 with `ser_mode`=10 (read), the pin shows the read-back bit. That bit captures `ser_bit` on the edge where `ce` rises and on every falling edge of `ser_clk` while `ce` is high. It reaches the pin one cycle after capture. The bit resets to 1.
- R9: The flag is tracked under any select code. Switching to 010 later shows the flag state built up before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Load strobe for the select register |
| sel_in | input | 3 | New select code |
| pll_locked | input | 1 | Loop lock status, 1 = locked |
| cnt_en | input | 1 | Counter enable bit; its rising edge starts a count |
| cnt_done | input | 1 | One-cycle pulse at the end of a counter measurement |
| io_lvl | input | IO_N | Asynchronous levels of the general I/O pins |
| io_is_out | input | IO_N | 1 = the I/O pin is configured as an output |
| ce | input | 1 | Serial chip enable |
| ser_mode | input | 2 | Serial mode: 00/01 write, 10 read, 11 treated as write |
| ser_clk | input | 1 | Serial clock level, sampled in the clk domain |
| ser_bit | input | 1 | Read-back data bit presented by the shift register |
| pin_n | output | 1 | Open-drain enable: 0 pulls low, 1 releases |

## Verification
Two events can land on the end-of-measurement flag in the same cycle: a measurement completing and a clear event (a new count start or a chip-enable rise). The bench drives `cnt_done` on the same edge as a rising `cnt_en`, and separately on the same edge as a rising `ce`. After chip enable drops, it checks at the pin that the flag remained set. A second collision happens between the serial override and the select mux: random bursts of chip enable arrive while the select code, lock status and flag are changing. Each cycle is compared with a bench reference model, so the override is judged in exactly the cycles where it must win.

// File: rtl/stat_pin_pkg.sv
package stat_pin_pkg;

  typedef enum logic [2:0] {
    SEL_REL0   = 3'b000,
    SEL_UNLOCK = 3'b001,
    SEL_EOM    = 3'b010,
    SEL_REL3   = 3'b011,
    SEL_REL4   = 3'b100,
    SEL_IOA    = 3'b101,
    SEL_IOB    = 3'b110,
    SEL_REL7   = 3'b111
  } sel_code_e;

  typedef enum logic [1:0] {
    MODE_WR_A = 2'b00,
    MODE_WR_B = 2'b01,
    MODE_RD   = 2'b10,
    MODE_RSV  = 2'b11
  } ser_mode_e;

  localparam int SEL_W  = 3;
  localparam int MODE_W = 2;

endpackage

// File: rtl/io_level_sync.sv
module io_level_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);

  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async[i]};
    end
    assign q_sync[i] = chain[LAST];
  end

endmodule

// File: rtl/eom_flag.sv
module eom_flag (
  input  logic clk,
  input  logic rst,
  input  logic cnt_en,
  input  logic cnt_done,
  input  logic ce,
  output logic flag
);

  logic cnt_en_q, ce_q;
  logic clr_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en_q <= 1'b0;
      ce_q     <= 1'b0;
    end else begin
      cnt_en_q <= cnt_en;
      ce_q     <= ce;
    end
  end

  assign clr_evt = (cnt_en & ~cnt_en_q) | (ce & ~ce_q);

  // completion wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (cnt_done) flag <= 1'b1;
    else if (clr_evt)  flag <= 1'b0;
  end

endmodule

// File: rtl/readback_bit.sv
module readback_bit (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic ser_clk,
  input  logic ser_bit,
  output logic rd_bit
);

  logic ce_q, sclk_q;
  logic take;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      ce_q   <= ce;
      sclk_q <= ser_clk;
    end
  end

  assign take = (ce & ~ce_q) | (ce & sclk_q & ~ser_clk);

  always_ff @(posedge clk) begin
    if (rst)       rd_bit <= 1'b1;
    else if (take) rd_bit <= ser_bit;
  end

endmodule

// File: rtl/stat_pin_sel.sv
module stat_pin_sel #(
  parameter int IO_N        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sel_we,
  input  logic [stat_pin_pkg::SEL_W-1:0] sel_in,
  input  logic                           pll_locked,
  input  logic                           cnt_en,
  input  logic                           cnt_done,
  input  logic [IO_N-1:0]                io_lvl,
  input  logic [IO_N-1:0]                io_is_out,
  input  logic                           ce,
  input  logic [stat_pin_pkg::MODE_W-1:0] ser_mode,
  input  logic                           ser_clk,
  input  logic                           ser_bit,
  output logic                           pin_n
);
  import stat_pin_pkg::*;

  sel_code_e       sel_q;
  logic [IO_N-1:0] io_s;
  logic            eom;
  logic            rd_bit;
  logic            pin_d;
  logic            rd_active, wr_active;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= SEL_REL0;
    else if (sel_we) sel_q <= sel_code_e'(sel_in);
  end

  io_level_sync #(.N(IO_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(io_lvl), .q_sync(io_s)
  );

  eom_flag u_eom (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_done(cnt_done),
    .ce(ce), .flag(eom)
  );

  readback_bit u_rb (
    .clk(clk), .rst(rst), .ce(ce), .ser_clk(ser_clk),
    .ser_bit(ser_bit), .rd_bit(rd_bit)
  );

  assign rd_active = ce && (ser_mode_e'(ser_mode) == MODE_RD);
  assign wr_active = ce && (ser_mode_e'(ser_mode) != MODE_RD);

  always_comb begin
    pin_d = 1'b1;
    if (rd_active) begin
      pin_d = rd_bit;
    end else if (wr_active) begin
      pin_d = 1'b1;
    end else begin
      unique case (sel_q)
        SEL_UNLOCK: pin_d = pll_locked;
        SEL_EOM:    pin_d = ~eom;
        SEL_IOA:    pin_d = io_is_out[0] ? 1'b1 : io_s[0];
        SEL_IOB:    pin_d = io_is_out[1] ? 1'b1 : io_s[1];
        default:    pin_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_n <= 1'b1;
    else     pin_n <= pin_d;
  end

endmodule

// File: rtl/stat_pin_chk.sv
module stat_pin_chk (
  input logic       clk,
  input logic       rst,
  input logic       ce,
  input logic [1:0] ser_mode,
  input logic [2:0] sel_q,
  input logic       pll_locked,
  input logic [1:0] io_is_out,
  input logic       eom,
  input logic       rd_bit,
  input logic       pin_n
);

  a_r1_reset_release: assert property (@(posedge clk) rst |=> pin_n)
    else $error("R1 pin not released after reset");

  a_r2_open_codes: assert property (@(posedge clk) disable iff (rst)
    (!ce && (sel_q == 3'b000 || sel_q == 3'b011 || sel_q == 3'b100 || sel_q == 3'b111)) |=> pin_n)
    else $error("R2 open code drove pin");

  a_r3_unlock_low: assert property (@(posedge clk) disable iff (rst)
    (!ce && sel_q == 3'b001 && !pll_locked) |=> !pin_n)
    else $error("R3 unlock not shown");

  a_r4_eom_low: assert property (@(posedge clk) disable iff (rst)
    (!ce && sel_q == 3'b010 && eom) |=> !pin_n)
    else $error("R4 flag not shown");

  a_r6_io_out_release: assert property (@(posedge clk) disable iff (rst)
    (!ce && ((sel_q == 3'b101 && io_is_out[0]) || (sel_q == 3'b110 && io_is_out[1]))) |=> pin_n)
    else $error("R6 output-configured io not released");

  a_r7_write_release: assert property (@(posedge clk) disable iff (rst)
    (ce && ser_mode != 2'b10) |=> pin_n)
    else $error("R7 pin driven in write mode");

  a_r8_read_bit: assert property (@(posedge clk) disable iff (rst)
    (ce && ser_mode == 2'b10) |=> (pin_n == $past(rd_bit)))
    else $error("R8 read-back bit mismatch");

endmodule

bind stat_pin_sel stat_pin_chk u_chk (
  .clk(clk), .rst(rst), .ce(ce), .ser_mode(ser_mode), .sel_q(sel_q),
  .pll_locked(pll_locked), .io_is_out(io_is_out), .eom(eom),
  .rd_bit(rd_bit), .pin_n(pin_n)
);

// File: tb/stat_pin_sel_bench.sv
module stat_pin_sel_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_we = 0;
  logic [2:0] sel_in = 0;
  logic pll_locked = 1;
  logic cnt_en = 0, cnt_done = 0;
  logic [1:0] io_lvl = 0, io_is_out = 0;
  logic ce = 0;
  logic [1:0] ser_mode = 0;
  logic ser_clk = 0, ser_bit = 0;
  logic pin_n;

  int n_chk = 0, n_fail = 0;
  bit done_run = 0;

  always #5 clk = ~clk;

  stat_pin_sel u_stat_pin_sel (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_in(sel_in),
    .pll_locked(pll_locked), .cnt_en(cnt_en), .cnt_done(cnt_done),
    .io_lvl(io_lvl), .io_is_out(io_is_out), .ce(ce), .ser_mode(ser_mode),
    .ser_clk(ser_clk), .ser_bit(ser_bit), .pin_n(pin_n)
  );

  // reference model built from the requirements
  logic [2:0] m_sel;
  logic [1:0] m_s1, m_s2;
  logic m_flag, m_cen_q, m_ce_q, m_sclk_q, m_rd, m_pin;
  string m_tag;

  function automatic logic exp_pin(logic [2:0] s, logic lk, logic fl,
                                   logic [1:0] io, logic [1:0] iout,
                                   logic c, logic [1:0] md, logic rd);
    if (c && md == 2'b10) return rd;
    if (c) return 1'b1;
    case (s)
      3'b001: return lk;
      3'b010: return ~fl;
      3'b101: return iout[0] ? 1'b1 : io[0];
      3'b110: return iout[1] ? 1'b1 : io[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] s, logic c, logic [1:0] md);
    if (c && md == 2'b10) return "R8";
    if (c) return "R7";
    case (s)
      3'b001: return "R3";
      3'b010: return "R4";
      3'b101, 3'b110: return "R6";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_s1 = 0; m_s2 = 0; m_flag = 0; m_cen_q = 0; m_ce_q = 0;
      m_sclk_q = 0; m_rd = 1; m_pin = 1; m_tag = "R1";
    end else begin
      logic nf, nrd;
      m_pin = exp_pin(m_sel, pll_locked, m_flag, m_s2, io_is_out, ce, ser_mode, m_rd);
      m_tag = tag_of(m_sel, ce, ser_mode);
      nf = cnt_done ? 1'b1 :
           (((cnt_en && !m_cen_q) || (ce && !m_ce_q)) ? 1'b0 : m_flag);
      nrd = ((ce && !m_ce_q) || (ce && m_sclk_q && !ser_clk)) ? ser_bit : m_rd;
      m_flag = nf; m_rd = nrd;
      m_s2 = m_s1; m_s1 = io_lvl;
      if (sel_we) m_sel = sel_in;
      m_cen_q = cnt_en; m_ce_q = ce; m_sclk_q = ser_clk;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pin_n actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic model_check(); check(m_tag, pin_n, m_pin); endtask

  task automatic set_sel(logic [2:0] v);
    sel_we = 1; sel_in = v; tick(); sel_we = 0; model_check();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) tick();
    check("R1", pin_n, 1'b1);
    rst = 0;
    tick(); check("R1", pin_n, 1'b1);
    // R1: select reset to 000 -> unlock has no effect
    pll_locked = 0; tick(); tick(); check("R1", pin_n, 1'b1);

    // R3 unlock indication
    set_sel(3'b001); tick(); check("R3", pin_n, 1'b0);
    pll_locked = 1; tick(); check("R3", pin_n, 1'b1);

    // R9: flag set while select is unlock, shown after switch
    cnt_done = 1; tick(); cnt_done = 0;
    set_sel(3'b010); tick(); check("R9", pin_n, 1'b0);
    // R4: stays low
    repeat (5) tick(); check("R4", pin_n, 1'b0);
    // R5: count start clears
    cnt_en = 1; tick(); tick(); check("R5", pin_n, 1'b1);
    cnt_en = 0; tick();
    cnt_done = 1; tick(); cnt_done = 0; tick(); check("R4", pin_n, 1'b0);
    // R5: ce rise clears (write mode), then shows released afterward
    ser_mode = 2'b00; ce = 1; tick(); ce = 0; tick(); tick();
    check("R5", pin_n, 1'b1);
    // R5 collision: done with count start
    cnt_en = 1; cnt_done = 1; tick(); cnt_done = 0; tick();
    check("R5", pin_n, 1'b0);
    cnt_en = 0; tick();
    // R5 collision: done with ce rise
    cnt_en = 1; tick(); cnt_en = 0; tick(); check("R5", pin_n, 1'b1);
    ce = 1; cnt_done = 1; tick(); cnt_done = 0; ce = 0; tick(); tick();
    check("R5", pin_n, 1'b0);

    // R6 io follow and output-config release
    set_sel(3'b101); io_lvl = 2'b00; repeat (4) tick(); check("R6", pin_n, 1'b0);
    io_lvl = 2'b01; tick(); tick(); check("R6", pin_n, 1'b0);
    tick(); check("R6", pin_n, 1'b1);
    io_lvl = 2'b00; repeat (4) tick(); io_is_out = 2'b01; tick(); check("R6", pin_n, 1'b1);
    io_is_out = 0; set_sel(3'b110); io_lvl = 2'b00; repeat (4) tick(); check("R6", pin_n, 1'b0);
    io_is_out = 2'b10; tick(); check("R6", pin_n, 1'b1);
    io_is_out = 0;

    // R7 write-mode override on an unlock select
    set_sel(3'b001); pll_locked = 0; tick();
    ser_mode = 2'b01; ce = 1; tick(); check("R7", pin_n, 1'b1);
    ser_mode = 2'b11; tick(); check("R7", pin_n, 1'b1);
    ce = 0; tick(); tick(); check("R3", pin_n, 1'b0);

    // R8 read-back: bit captured at ce rise, then on falling ser_clk
    ser_mode = 2'b10; ser_bit = 0; ser_clk = 0; ce = 1; tick();
    tick(); check("R8", pin_n, 1'b0);
    ser_bit = 1; ser_clk = 1; tick(); tick(); check("R8", pin_n, 1'b0);
    ser_clk = 0; tick(); tick(); check("R8", pin_n, 1'b1);
    ce = 0; pll_locked = 1; tick(); tick();

    // R2 open codes
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 3 || c == 4 || c == 7) begin
        pll_locked = 0; cnt_done = 1; set_sel(3'(c)); cnt_done = 0;
        tick(); check("R2", pin_n, 1'b1);
      end
    end
    pll_locked = 1;

    // constrained random against the reference model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) begin sel_we = 1; sel_in = 3'($urandom_range(0, 7)); end
      else sel_we = 0;
      if ($urandom_range(0, 7) == 0) pll_locked = ~pll_locked;
      cnt_done = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 11) == 0) cnt_en = ~cnt_en;
      if ($urandom_range(0, 5) == 0) io_lvl = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) io_is_out = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 13) == 0) begin
        ce = ~ce;
        if (ce) ser_mode = 2'($urandom_range(0, 3));
      end
      ser_clk = 1'($urandom_range(0, 1));
      ser_bit = 1'($urandom_range(0, 1));
      tick();
      model_check();
    end

    done_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule